// File: doc/BRIEF.md
# Packet Command Phase Sequencer

This block follows one packet command through its life on a packet-protocol storage device. The host asks it to start a command. The block then waits for device interrupts. On each interrupt it builds a 3-bit phase event from the interrupt-reason bits and the data-request bit. A fixed lookup, indexed by the current phase and that event, gives two results: the action to take and the phase that follows.

Each action appears as a one-cycle strobe, and the data movers, the packet writer and the DMA engine outside the block act on those strobes. Some devices do not follow the protocol exactly. They may drop the data request between data phases, or report a wrong reason code at the status phase. The block tolerates both: it raises a warning or a tolerant completion instead of hanging.

When a command runs in DMA mode, an interrupt first stops the DMA engine through a request/acknowledge handshake. Status is sampled only after that acknowledge. A completion reports an error flag built from the fault bits. After a clean DMA completion it also reports that the residual byte count is zero.

Top module: `pkt_phase_seq`

## Requirements
- R1: A command request is accepted only in Idle. Acceptance pulses `cmd_accept` and moves `seq_state` to Cmd. A request in any other phase pulses `cmd_refused` and leaves the phase unchanged. The phase codes on `seq_state` are Idle=0, Cmd=1, Cdb=2, DataIn=3, DataOut=4, DmaActive=5.
- R2: The event code is {`rsn_io`, `rsn_cod`, `stat_drq`}. In Cmd:
  - event 3 pulses `act_send_pkt` and moves to Cdb;
  - event 6 completes the command and returns to Idle;
  - event 7 keeps Cmd;
  - every other event moves to Cdb with no action.
- R3: In Cdb:
  - event 1 pulses `act_data_out` and moves to DataOut;
  - event 5 pulses `act_data_in` and moves to DataIn;
  - events 2 and 3 stay in Cdb with no action;
  - event 4 pulses `act_idle_warn` and stays in Cdb.
- R4: Event 6 in any phase other than Idle pulses `act_complete` and returns to Idle. Event 0 in Cdb, DataIn, DataOut or DmaActive pulses both `act_complete` and `act_tol_complete`, and returns to Idle.
- R5: In DataIn and DataOut:
  - events 2 and 4 pulse `act_idle_warn`;
  - event 5 in DataIn and event 1 in DataOut repeat the transfer strobe;
  - event 7, event 3 and the opposite-direction data event pulse `act_unknown`.
  In all of these cases the phase is kept.
- R6: If the packet is sent on a command flagged for DMA, the block pulses `dma_start` together with `act_send_pkt` and enters DmaActive. In DmaActive, every event except 0 and 6 pulses `act_unknown` and keeps DmaActive.
- R7: An interrupt in DmaActive raises `dma_stop_req`, with no action and no phase change. The request holds until `dma_stop_ack` is high. Status and reason inputs are evaluated in that acknowledge cycle, and the request drops.
- R8: If `stat_bsy` is high when an interrupt is evaluated, `irq_busy` pulses and the event is ignored: no action strobe, and no phase change.
- R9: A data-in action on a command not flagged as a read, or a data-out action on one not flagged as a write, pulses `proto_err` instead of the transfer strobe. The phase still follows the lookup.
- R10: `rpt_idle_warn` pulses with only the first idle warning after reset. `rpt_tol_complete` pulses with only the first tolerant completion after reset.
- R11: On completion, `cmd_error` becomes `stat_df | stat_err`. `resid_zero` becomes 1 when the completion came from DmaActive with neither fault bit set, and 0 otherwise. Both hold until the next acceptance, which clears them.
- R12: All outputs are registered and change one clock after the cycle in which the request, interrupt or acknowledge is presented. At most one of the action strobes, `proto_err` and `irq_busy` pulses in any cycle, with one exception: a tolerant completion pulses `act_complete` and `act_tol_complete` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Start a new command |
| cmd_rd | input | 1 | Command reads from the device |
| cmd_wr | input | 1 | Command writes to the device |
| cmd_dma | input | 1 | Command uses DMA |
| cmd_accept | output | 1 | Request accepted (pulse) |
| cmd_refused | output | 1 | Request refused as busy (pulse) |
| irq | input | 1 | Device interrupt, with status sampled the same cycle |
| stat_bsy | input | 1 | Device busy bit |
| stat_drq | input | 1 | Data request bit |
| stat_df | input | 1 | Device fault bit |
| stat_err | input | 1 | Error bit |
| rsn_io | input | 1 | Reason: transfer toward host |
| rsn_cod | input | 1 | Reason: command/status, not data |
| dma_stop_req | output | 1 | Request to halt the DMA engine |
| dma_stop_ack | input | 1 | DMA engine halted |
| dma_start | output | 1 | Start the DMA engine (pulse) |
| act_send_pkt | output | 1 | Send the command packet (pulse) |
| act_data_in | output | 1 | Move a data block from the device (pulse) |
| act_data_out | output | 1 | Move a data block to the device (pulse) |
| act_complete | output | 1 | Command complete, read status (pulse) |
| act_tol_complete | output | 1 | Completion taken on a wrong reason code (pulse) |
| act_idle_warn | output | 1 | Data request dropped during a data phase (pulse) |
| act_unknown | output | 1 | Event not valid in this phase (pulse) |
| proto_err | output | 1 | Data direction does not match the command (pulse) |
| irq_busy | output | 1 | Interrupt ignored because the device is busy (pulse) |
| rpt_idle_warn | output | 1 | First idle warning since reset (pulse) |
| rpt_tol_complete | output | 1 | First tolerant completion since reset (pulse) |
| cmd_error | output | 1 | Last completion had a fault |
| resid_zero | output | 1 | Last completion was a clean DMA completion |
| seq_state | output | 3 | Current phase code |

## Verification
The bench builds the block with the defaults `USE_DMA=1` and `REPORT_ONCE=1`. This makes the DmaActive phase, the stop handshake and the residual-zero result reachable. It also means a second warning or tolerant completion must stay silent on the report outputs. Command sequences cover each phase's legal and illegal events, a busy interrupt both before the packet and inside the DMA handshake, a direction mismatch, and completions with and without fault bits.

// File: rtl/pkt_phase_pkg.sv
package pkt_phase_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CMD  = 3'd1,
      PH_CDB  = 3'd2,
      PH_RX   = 3'd3,
      PH_TX   = 3'd4,
      PH_DMA  = 3'd5
   } ph_state_t;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_SEND,
      ACT_RX,
      ACT_TX,
      ACT_WARN,
      ACT_DONE,
      ACT_TOL,
      ACT_UNK
   } ph_act_t;

   localparam logic [2:0] EV_BAD0 = 3'd0;
   localparam logic [2:0] EV_TX   = 3'd1;
   localparam logic [2:0] EV_IDLE = 3'd2;
   localparam logic [2:0] EV_PKT  = 3'd3;
   localparam logic [2:0] EV_BAD4 = 3'd4;
   localparam logic [2:0] EV_RX   = 3'd5;
   localparam logic [2:0] EV_STAT = 3'd6;
   localparam logic [2:0] EV_RSV  = 3'd7;

   typedef struct packed {
      ph_act_t   act;
      ph_state_t nxt;
   } ph_step_t;

   function automatic ph_step_t mk(input ph_act_t a, input ph_state_t n);
      ph_step_t r;
      r.act = a;
      r.nxt = n;
      return r;
   endfunction

   // Action and successor phase for one (phase, event) pair.
   function automatic ph_step_t ph_lookup(input ph_state_t s, input logic [2:0] ev);
      ph_step_t r;
      r = mk(ACT_NONE, s);
      case (s)
         PH_IDLE: r = mk(ACT_NONE, PH_IDLE);
         PH_CMD: begin
            case (ev)
               EV_PKT:  r = mk(ACT_SEND, PH_CDB);
               EV_STAT: r = mk(ACT_DONE, PH_IDLE);
               EV_RSV:  r = mk(ACT_NONE, PH_CMD);
               default: r = mk(ACT_NONE, PH_CDB);
            endcase
         end
         PH_CDB: begin
            case (ev)
               EV_BAD0: r = mk(ACT_TOL,  PH_IDLE);
               EV_TX:   r = mk(ACT_TX,   PH_TX);
               EV_IDLE: r = mk(ACT_NONE, PH_CDB);
               EV_PKT:  r = mk(ACT_NONE, PH_CDB);
               EV_BAD4: r = mk(ACT_WARN, PH_CDB);
               EV_RX:   r = mk(ACT_RX,   PH_RX);
               EV_STAT: r = mk(ACT_DONE, PH_IDLE);
               default: r = mk(ACT_UNK,  PH_CDB);
            endcase
         end
         PH_RX: begin
            case (ev)
               EV_BAD0: r = mk(ACT_TOL,  PH_IDLE);
               EV_IDLE: r = mk(ACT_WARN, PH_RX);
               EV_BAD4: r = mk(ACT_WARN, PH_RX);
               EV_RX:   r = mk(ACT_RX,   PH_RX);
               EV_STAT: r = mk(ACT_DONE, PH_IDLE);
               default: r = mk(ACT_UNK,  PH_RX);
            endcase
         end
         PH_TX: begin
            case (ev)
               EV_BAD0: r = mk(ACT_TOL,  PH_IDLE);
               EV_TX:   r = mk(ACT_TX,   PH_TX);
               EV_IDLE: r = mk(ACT_WARN, PH_TX);
               EV_BAD4: r = mk(ACT_WARN, PH_TX);
               EV_STAT: r = mk(ACT_DONE, PH_IDLE);
               default: r = mk(ACT_UNK,  PH_TX);
            endcase
         end
         PH_DMA: begin
            case (ev)
               EV_BAD0: r = mk(ACT_TOL,  PH_IDLE);
               EV_STAT: r = mk(ACT_DONE, PH_IDLE);
               default: r = mk(ACT_UNK,  PH_DMA);
            endcase
         end
         default: r = mk(ACT_NONE, PH_IDLE);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pkt_phase_decode.sv
module pkt_phase_decode
   import pkt_phase_pkg::*;
(
   input  ph_state_t  cur,
   input  logic       io,
   input  logic       cod,
   input  logic       drq,
   output logic [2:0] ev,
   output ph_step_t   step
);
   always_comb begin
      ev   = {io, cod, drq};
      step = ph_lookup(cur, ev);
   end
endmodule

// File: rtl/pkt_phase_report.sv
module pkt_phase_report #(
   parameter int ONCE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic rpt
);
   generate
      if (ONCE != 0) begin : g_once
         logic seen_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   seen_q <= 1'b0;
            else if (hit) seen_q <= 1'b1;
         end
         assign rpt = hit && !seen_q;
      end else begin : g_every
         assign rpt = hit;
      end
   endgenerate
endmodule

// File: rtl/pkt_phase_seq.sv
module pkt_phase_seq
   import pkt_phase_pkg::*;
#(
   parameter int USE_DMA     = 1,
   parameter int REPORT_ONCE = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_req,
   input  logic       cmd_rd,
   input  logic       cmd_wr,
   input  logic       cmd_dma,
   output logic       cmd_accept,
   output logic       cmd_refused,
   input  logic       irq,
   input  logic       stat_bsy,
   input  logic       stat_drq,
   input  logic       stat_df,
   input  logic       stat_err,
   input  logic       rsn_io,
   input  logic       rsn_cod,
   output logic       dma_stop_req,
   input  logic       dma_stop_ack,
   output logic       dma_start,
   output logic       act_send_pkt,
   output logic       act_data_in,
   output logic       act_data_out,
   output logic       act_complete,
   output logic       act_tol_complete,
   output logic       act_idle_warn,
   output logic       act_unknown,
   output logic       proto_err,
   output logic       irq_busy,
   output logic       rpt_idle_warn,
   output logic       rpt_tol_complete,
   output logic       cmd_error,
   output logic       resid_zero,
   output logic [2:0] seq_state
);
   initial begin
      if (USE_DMA != 0 && USE_DMA != 1)         $error("USE_DMA must be 0 or 1");
      if (REPORT_ONCE != 0 && REPORT_ONCE != 1) $error("REPORT_ONCE must be 0 or 1");
   end

   ph_state_t  cur_q, nxt;
   logic       pend_q;
   logic       rd_q, wr_q, dma_q, dma_sel;
   logic [2:0] ev;
   ph_step_t   step;

   pkt_phase_decode u_dec (
      .cur  (cur_q),
      .io   (rsn_io),
      .cod  (rsn_cod),
      .drq  (stat_drq),
      .ev   (ev),
      .step (step)
   );

   generate
      if (USE_DMA != 0) begin : g_dma
         assign dma_sel = dma_q;
      end else begin : g_nodma
         assign dma_sel = 1'b0;
      end
   endgenerate

   logic eval_now, stop_set, take, busy_hit, accept, refuse;
   logic warn_hit, tol_hit, cmpl_hit, err_now;
   logic rpt_w, rpt_t;
   ph_act_t act;

   always_comb begin
      stop_set = irq && (cur_q == PH_DMA) && !pend_q;
      eval_now = (irq && (cur_q != PH_DMA) && !pend_q) || (pend_q && dma_stop_ack);
      busy_hit = eval_now && stat_bsy;
      take     = eval_now && !stat_bsy;
      act      = take ? step.act : ACT_NONE;
      accept   = cmd_req && (cur_q == PH_IDLE) && !pend_q;
      refuse   = cmd_req && !accept;
      warn_hit = (act == ACT_WARN);
      tol_hit  = (act == ACT_TOL);
      cmpl_hit = (act == ACT_DONE) || tol_hit;
      err_now  = stat_df || stat_err;
      nxt      = cur_q;
      if (accept)
         nxt = PH_CMD;
      else if (take) begin
         if (act == ACT_SEND && dma_sel) nxt = PH_DMA;
         else                            nxt = step.nxt;
      end
   end

   pkt_phase_report #(.ONCE(REPORT_ONCE)) u_rpt_warn (
      .clk(clk), .rst_n(rst_n), .hit(warn_hit), .rpt(rpt_w)
   );
   pkt_phase_report #(.ONCE(REPORT_ONCE)) u_rpt_tol (
      .clk(clk), .rst_n(rst_n), .hit(tol_hit), .rpt(rpt_t)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q            <= PH_IDLE;
         pend_q           <= 1'b0;
         rd_q             <= 1'b0;
         wr_q             <= 1'b0;
         dma_q            <= 1'b0;
         cmd_accept       <= 1'b0;
         cmd_refused      <= 1'b0;
         dma_start        <= 1'b0;
         act_send_pkt     <= 1'b0;
         act_data_in      <= 1'b0;
         act_data_out     <= 1'b0;
         act_complete     <= 1'b0;
         act_tol_complete <= 1'b0;
         act_idle_warn    <= 1'b0;
         act_unknown      <= 1'b0;
         proto_err        <= 1'b0;
         irq_busy         <= 1'b0;
         rpt_idle_warn    <= 1'b0;
         rpt_tol_complete <= 1'b0;
         cmd_error        <= 1'b0;
         resid_zero       <= 1'b0;
      end else begin
         cur_q <= nxt;
         if (stop_set)                    pend_q <= 1'b1;
         else if (pend_q && dma_stop_ack) pend_q <= 1'b0;
         if (accept) begin
            rd_q  <= cmd_rd;
            wr_q  <= cmd_wr;
            dma_q <= cmd_dma;
         end
         cmd_accept       <= accept;
         cmd_refused      <= refuse;
         act_send_pkt     <= (act == ACT_SEND);
         dma_start        <= (act == ACT_SEND) && dma_sel;
         act_data_in      <= (act == ACT_RX) && rd_q;
         act_data_out     <= (act == ACT_TX) && wr_q;
         proto_err        <= ((act == ACT_RX) && !rd_q) || ((act == ACT_TX) && !wr_q);
         act_complete     <= cmpl_hit;
         act_tol_complete <= tol_hit;
         act_idle_warn    <= warn_hit;
         act_unknown      <= (act == ACT_UNK);
         irq_busy         <= busy_hit;
         rpt_idle_warn    <= rpt_w;
         rpt_tol_complete <= rpt_t;
         if (accept) begin
            cmd_error  <= 1'b0;
            resid_zero <= 1'b0;
         end else if (cmpl_hit) begin
            cmd_error  <= err_now;
            resid_zero <= (cur_q == PH_DMA) && !err_now;
         end
      end
   end

   assign dma_stop_req = pend_q;
   assign seq_state    = cur_q;

endmodule

// File: rtl/pkt_phase_seq_chk.sv
module pkt_phase_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_accept,
   input logic       cmd_refused,
   input logic       irq_busy,
   input logic       dma_start,
   input logic       dma_stop_req,
   input logic       act_send_pkt,
   input logic       act_data_in,
   input logic       act_data_out,
   input logic       act_complete,
   input logic       act_idle_warn,
   input logic       act_unknown,
   input logic       proto_err,
   input logic       cmd_error,
   input logic       resid_zero,
   input logic [2:0] seq_state
);
   // R1
   accept_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_accept |-> seq_state == 3'd1);
   // R1
   accept_refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_accept && cmd_refused));
   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_busy && !cmd_accept) |-> $stable(seq_state));
   // R6
   dma_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 3'd5 && $past(seq_state) != 3'd5) |-> dma_start);
   // R7
   stop_in_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_stop_req |-> seq_state == 3'd5);
   // R4
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_complete |-> seq_state == 3'd0);
   // R9
   rx_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_data_in |-> seq_state == 3'd3);
   // R11
   rz_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resid_zero |-> !cmd_error);
   // R12
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_send_pkt, act_data_in, act_data_out, act_complete,
                act_idle_warn, act_unknown, proto_err, irq_busy}));
endmodule

bind pkt_phase_seq pkt_phase_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_accept   (cmd_accept),
   .cmd_refused  (cmd_refused),
   .irq_busy     (irq_busy),
   .dma_start    (dma_start),
   .dma_stop_req (dma_stop_req),
   .act_send_pkt (act_send_pkt),
   .act_data_in  (act_data_in),
   .act_data_out (act_data_out),
   .act_complete (act_complete),
   .act_idle_warn(act_idle_warn),
   .act_unknown  (act_unknown),
   .proto_err    (proto_err),
   .cmd_error    (cmd_error),
   .resid_zero   (resid_zero),
   .seq_state    (seq_state)
);

// File: tb/pkt_phase_seq_tb.sv
`timescale 1ns/1ps
module pkt_phase_seq_tb_top;

   localparam logic [14:0] M_SEND  = 15'h0001;
   localparam logic [14:0] M_DIN   = 15'h0002;
   localparam logic [14:0] M_DOUT  = 15'h0004;
   localparam logic [14:0] M_DONE  = 15'h0008;
   localparam logic [14:0] M_TOL   = 15'h0010;
   localparam logic [14:0] M_WARN  = 15'h0020;
   localparam logic [14:0] M_UNK   = 15'h0040;
   localparam logic [14:0] M_PROTO = 15'h0080;
   localparam logic [14:0] M_IBUSY = 15'h0100;
   localparam logic [14:0] M_ACC   = 15'h0200;
   localparam logic [14:0] M_REF   = 15'h0400;
   localparam logic [14:0] M_DMAST = 15'h0800;
   localparam logic [14:0] M_RPTW  = 15'h1000;
   localparam logic [14:0] M_RPTT  = 15'h2000;
   localparam logic [14:0] M_STOP  = 15'h4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_req = 0, cmd_rd = 0, cmd_wr = 0, cmd_dma = 0;
   logic irq = 0, stat_bsy = 0, stat_drq = 0, stat_df = 0, stat_err = 0;
   logic rsn_io = 0, rsn_cod = 0, dma_stop_ack = 0;
   logic cmd_accept, cmd_refused, dma_stop_req, dma_start;
   logic act_send_pkt, act_data_in, act_data_out, act_complete, act_tol_complete;
   logic act_idle_warn, act_unknown, proto_err, irq_busy;
   logic rpt_idle_warn, rpt_tol_complete, cmd_error, resid_zero;
   logic [2:0] seq_state;

   always #2.5 clk = ~clk;

   pkt_phase_seq #(.USE_DMA(1), .REPORT_ONCE(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_req(cmd_req), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_dma(cmd_dma),
      .cmd_accept(cmd_accept), .cmd_refused(cmd_refused),
      .irq(irq), .stat_bsy(stat_bsy), .stat_drq(stat_drq), .stat_df(stat_df),
      .stat_err(stat_err), .rsn_io(rsn_io), .rsn_cod(rsn_cod),
      .dma_stop_req(dma_stop_req), .dma_stop_ack(dma_stop_ack), .dma_start(dma_start),
      .act_send_pkt(act_send_pkt), .act_data_in(act_data_in), .act_data_out(act_data_out),
      .act_complete(act_complete), .act_tol_complete(act_tol_complete),
      .act_idle_warn(act_idle_warn), .act_unknown(act_unknown), .proto_err(proto_err),
      .irq_busy(irq_busy), .rpt_idle_warn(rpt_idle_warn), .rpt_tol_complete(rpt_tol_complete),
      .cmd_error(cmd_error), .resid_zero(resid_zero), .seq_state(seq_state)
   );

   typedef struct {
      string       tag;
      logic [14:0] strb;
      logic [2:0]  st;
      logic        err;
      logic        rz;
   } exp_t;

   exp_t sb_q[$];
   int checks = 0;
   int failures = 0;
   bit finished = 0;

   wire [14:0] obs = {dma_stop_req, rpt_tol_complete, rpt_idle_warn, dma_start,
                      cmd_refused, cmd_accept, irq_busy, proto_err, act_unknown,
                      act_idle_warn, act_tol_complete, act_complete, act_data_out,
                      act_data_in, act_send_pkt};

   // Monitor: compare the oldest expected item with the registered outputs.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (obs !== e.strb || seq_state !== e.st || cmd_error !== e.err || resid_zero !== e.rz) begin
            failures++;
            $display("FAIL %s: actual strb=%h st=%0d err=%0b rz=%0b expected strb=%h st=%0d err=%0b rz=%0b",
                     e.tag, obs, seq_state, cmd_error, resid_zero, e.strb, e.st, e.err, e.rz);
         end
      end
   end

   task automatic clear_in();
      cmd_req = 0; cmd_rd = 0; cmd_wr = 0; cmd_dma = 0;
      irq = 0; stat_bsy = 0; stat_drq = 0; stat_df = 0; stat_err = 0;
      rsn_io = 0; rsn_cod = 0; dma_stop_ack = 0;
   endtask

   task automatic req(input logic rd, input logic wr, input logic dma);
      cmd_req = 1; cmd_rd = rd; cmd_wr = wr; cmd_dma = dma;
   endtask

   task automatic setst(input logic [2:0] code, input logic bsy, input logic er, input logic df);
      rsn_io = code[2]; rsn_cod = code[1]; stat_drq = code[0];
      stat_bsy = bsy; stat_err = er; stat_df = df;
   endtask

   task automatic ev(input logic [2:0] code, input logic bsy = 0, input logic er = 0, input logic df = 0);
      irq = 1;
      setst(code, bsy, er, df);
   endtask

   task automatic ack(input logic [2:0] code, input logic bsy = 0, input logic er = 0, input logic df = 0);
      dma_stop_ack = 1;
      setst(code, bsy, er, df);
   endtask

   // Driver: one clock with the inputs set, then queue the expected outcome.
   task automatic go(input string tag, input logic [2:0] st, input logic [14:0] m,
                     input logic er = 0, input logic rz = 0);
      exp_t e;
      @(posedge clk);
      e.tag = tag; e.strb = m; e.st = st; e.err = er; e.rz = rz;
      sb_q.push_back(e);
      @(negedge clk);
      clear_in();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      clear_in();
      repeat (3) @(negedge clk);
      rst_n = 1;
      go("R12 reset state", 3'd0, 15'h0);

      // read command, PIO
      req(1, 0, 0); go("R1 accept in idle", 3'd1, M_ACC);
      req(1, 0, 0); go("R1 refuse when active", 3'd1, M_REF);
      ev(3'd3, 1);  go("R8 busy interrupt ignored", 3'd1, M_IBUSY);
      ev(3'd3);     go("R2 cmd send packet", 3'd2, M_SEND);
      ev(3'd2);     go("R3 cdb idle event no action", 3'd2, 15'h0);
      ev(3'd4);     go("R3 R10 cdb warn first report", 3'd2, M_WARN | M_RPTW);
      ev(3'd5);     go("R3 cdb data in", 3'd3, M_DIN);
      ev(3'd2);     go("R5 R10 datain warn no report", 3'd3, M_WARN);
      ev(3'd1);     go("R5 datain unknown", 3'd3, M_UNK);
      ev(3'd6, 0, 1); go("R4 R11 status with error", 3'd0, M_DONE, 1'b1, 1'b0);

      // write command receiving an input phase
      req(0, 1, 0); go("R1 R11 accept clears flags", 3'd1, M_ACC);
      ev(3'd3);     go("R2 send packet", 3'd2, M_SEND);
      ev(3'd5);     go("R9 direction mismatch", 3'd3, M_PROTO);
      ev(3'd0);     go("R4 R10 tolerant first report", 3'd0, M_DONE | M_TOL | M_RPTT);

      // status directly from Cmd
      req(0, 1, 0); go("R1 accept", 3'd1, M_ACC);
      ev(3'd6, 0, 0, 1); go("R2 R11 cmd status fault", 3'd0, M_DONE, 1'b1, 1'b0);

      // write command, PIO
      req(0, 1, 0); go("R1 accept write", 3'd1, M_ACC);
      ev(3'd3);     go("R2 send packet", 3'd2, M_SEND);
      ev(3'd1);     go("R3 cdb data out", 3'd4, M_DOUT);
      ev(3'd1);     go("R5 dataout repeat", 3'd4, M_DOUT);
      ev(3'd4);     go("R5 dataout warn", 3'd4, M_WARN);
      ev(3'd5);     go("R5 dataout unknown", 3'd4, M_UNK);
      ev(3'd6);     go("R4 clean completion", 3'd0, M_DONE);

      // DMA read
      req(1, 0, 1); go("R1 accept dma", 3'd1, M_ACC);
      ev(3'd3);     go("R6 send forces dma", 3'd5, M_SEND | M_DMAST);
      ev(3'd5);     go("R7 stop request raised", 3'd5, M_STOP);
      go("R7 stop request held", 3'd5, M_STOP);
      ack(3'd5);    go("R6 R7 dma unknown after ack", 3'd5, M_UNK);
      ev(3'd6);     go("R7 stop before status", 3'd5, M_STOP);
      ack(3'd6);    go("R11 dma clean resid zero", 3'd0, M_DONE, 1'b0, 1'b1);

      // DMA with busy in handshake and tolerant completion
      req(1, 0, 1); go("R1 accept dma again", 3'd1, M_ACC);
      ev(3'd3);     go("R6 send dma", 3'd5, M_SEND | M_DMAST);
      ev(3'd0);     go("R7 stop request", 3'd5, M_STOP);
      ack(3'd0, 1); go("R8 busy at ack", 3'd5, M_IBUSY);
      ev(3'd0);     go("R7 stop request again", 3'd5, M_STOP);
      ack(3'd0, 0, 1); go("R4 R10 R11 tolerant no report", 3'd0, M_DONE | M_TOL, 1'b1, 1'b0);

      ev(3'd6);     go("R2 interrupt in idle no action", 3'd0, 15'h0, 1'b1, 1'b0);

      @(negedge clk);
      if (sb_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R12 queue: actual=%0d expected=0", sb_q.size());
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule